// File: doc/BRIEF.md
# Programmable Parallel Memory Bus Controller

This block sits between an internal request port and an external parallel bus that serves NOR flash, FPGA register files, UART chips and similar parts. Each accepted request becomes one single read or write cycle on the bus. The cycle has a fixed sequence of phases: a setup time with chip enable inactive, an address-valid strobe, an optional window in which the address stays on a shared address/data bus, a write-enable or output-enable strobe, and a hold time in which chip enable stays active. Every phase length comes from a configuration field. A field value N gives N+1 clock cycles.

A configuration register set holds the phase lengths, the 16/32-bit data width, address/data multiplexing, early-ready mode and the active level of each strobe. It loads from the `cfg_*` pins on a `cfg_wr` pulse, but only while the controller is idle. The request port follows valid/ready rules. `req_ready` is high only when no bus cycle is in progress, and a request is taken on a cycle where both `req_valid` and `req_ready` are high. The requester applies back-pressure simply by holding `req_valid` low. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse and the consumer must take `rsp_rdata` in that cycle. The block does no chip-select address decoding. It drives one chip enable for its 256 MB window and leaves any further decoding to external logic.

Top module: `pmb_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the controller is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high from the cycle after acceptance through the last hold cycle, and low otherwise.
- R2: After acceptance the phases run in this order: setup (chip enable inactive, t_setup+1 cycles), address valid (chip enable and address valid active, t_adv+1 cycles), the multiplex window if enabled, the data phase, then hold. `bus_addr` carries the request address while busy and zero while idle.
- R3: On a write, write enable is active for t_we+1 cycles. `bus_doe` is high and `bus_dout` carries the write data during the write-enable and hold phases. Output enable stays inactive.
- R4: After write enable (write) or output enable (read) deasserts, chip enable stays active for t_hold+1 cycles. All strobes are then inactive and the controller is idle.
- R5: With multiplexing enabled, `bus_doe` is high and `bus_dout` carries the address during the address-valid phase and a following window of t_mux+1 cycles with address valid inactive. With multiplexing disabled there is no such window and `bus_dout` does not carry the address.
- R6: On a read, output enable becomes active when the data phase starts. Ready is ignored during the first t_wait+1 cycles of that phase. In normal mode, `bus_din` is captured in the first later cycle in which ready is at its active level.
- R7: In early-ready mode, `bus_din` is captured one cycle after the first cycle, past the wait window, in which ready is at its active level.
- R8: Output enable stays active for at least t_oe+1 cycles, and for longer if needed until data has been captured.
- R9: `rsp_valid` is high for exactly one cycle, the cycle after capture, and `rsp_rdata` then holds the captured word.
- R10: `cfg_wide`=0 selects 16-bit data. Only bits 15:0 of the write data (or of the multiplexed address) appear on `bus_dout`, and `rsp_rdata` is `bus_din[15:0]` zero-extended. `cfg_wide`=1 uses all 32 bits.
- R11: Each polarity bit (`cfg_ce_high`, `cfg_adv_high`, `cfg_strobe_high` for write/output enable, `cfg_rdy_high`) makes that signal active-high when set. When clear, the signal is active-low.
- R12: After reset the fields are t_setup=4, t_wait=3, and t_adv=t_mux=t_we=t_hold=t_oe=1, with all mode and polarity bits 0. A `cfg_wr` in a busy cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Load configuration from the cfg_* pins (idle only) |
| cfg_wide | input | 1 | 1: 32-bit data, 0: 16-bit |
| cfg_mux | input | 1 | Address/data multiplexing enable |
| cfg_rdy_early | input | 1 | Ready arrives one cycle ahead of data |
| cfg_rdy_high | input | 1 | Ready active-high |
| cfg_adv_high | input | 1 | Address valid active-high |
| cfg_strobe_high | input | 1 | Write/output enable active-high |
| cfg_ce_high | input | 1 | Chip enable active-high |
| cfg_t_setup | input | 4 | Setup length before chip enable, minus one |
| cfg_t_adv | input | 4 | Address-valid length, minus one |
| cfg_t_mux | input | 4 | Multiplex window length, minus one |
| cfg_t_we | input | 4 | Write-enable length, minus one |
| cfg_t_hold | input | 4 | Hold length, minus one |
| cfg_t_oe | input | 8 | Minimum output-enable length, minus one |
| cfg_t_wait | input | 8 | Ready-ignore window, minus one |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 28 | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 32 | Read data |
| busy | output | 1 | Bus cycle in progress |
| bus_ce | output | 1 | Chip enable (configured polarity) |
| bus_adv | output | 1 | Address valid (configured polarity) |
| bus_we | output | 1 | Write enable (configured polarity) |
| bus_oe | output | 1 | Output enable (configured polarity) |
| bus_addr | output | 28 | Address bus |
| bus_dout | output | 32 | Data bus out |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | 32 | Data bus in |
| bus_rdy | input | 1 | Ready from device (configured polarity) |

## Verification
The assertions check these rules on every cycle: configuration stays frozen while busy, chip enable covers every other strobe, write and output enable never overlap, a hold phase only follows a data phase, output enable never ends before its minimum, and a response is a lone pulse. Other behaviour can only be shown by the bench's scenarios, which compare every output against a behavioural timeline on every cycle. That covers the exact phase lengths, the cycle in which read data is captured (normal and early ready, ready present during the ignore window, ready late enough to stretch output enable), narrow-mode masking and each polarity setting.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  localparam int SHORT_W = 4;
  localparam int LONG_W  = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ADV,
    PH_MUXA,
    PH_DATA,
    PH_HOLD
  } pmb_phase_e;

  typedef struct packed {
    logic              wide;
    logic              mux;
    logic              rdy_early;
    logic              rdy_high;
    logic              adv_high;
    logic              strobe_high;
    logic              ce_high;
    logic [SHORT_W-1:0] t_setup;
    logic [SHORT_W-1:0] t_adv;
    logic [SHORT_W-1:0] t_mux;
    logic [SHORT_W-1:0] t_we;
    logic [SHORT_W-1:0] t_hold;
    logic [LONG_W-1:0]  t_oe;
    logic [LONG_W-1:0]  t_wait;
  } pmb_cfg_t;
endpackage

// File: rtl/pmb_cfg_regs.sv
module pmb_cfg_regs
  import pmb_pkg::*;
#(
  parameter int DEF_SETUP = 4,
  parameter int DEF_ADV   = 1,
  parameter int DEF_MUX   = 1,
  parameter int DEF_WE    = 1,
  parameter int DEF_HOLD  = 1,
  parameter int DEF_OE    = 1,
  parameter int DEF_WAIT  = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     busy,
  input  logic     wr,
  input  pmb_cfg_t wr_val,
  output pmb_cfg_t cfg
);
  pmb_cfg_t reset_val;

  always_comb begin
    reset_val             = '0;
    reset_val.t_setup     = SHORT_W'(DEF_SETUP);
    reset_val.t_adv       = SHORT_W'(DEF_ADV);
    reset_val.t_mux       = SHORT_W'(DEF_MUX);
    reset_val.t_we        = SHORT_W'(DEF_WE);
    reset_val.t_hold      = SHORT_W'(DEF_HOLD);
    reset_val.t_oe        = LONG_W'(DEF_OE);
    reset_val.t_wait      = LONG_W'(DEF_WAIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cfg <= reset_val;
    else if (wr && !busy) cfg <= wr_val;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg)) else $error("configuration changed while busy"); // R12
endmodule

// File: rtl/pmb_seq.sv
module pmb_seq
  import pmb_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_wide,
  input  logic              c_mux,
  input  logic              c_early,
  input  logic [SHORT_W-1:0] c_setup,
  input  logic [SHORT_W-1:0] c_adv,
  input  logic [SHORT_W-1:0] c_muxw,
  input  logic [SHORT_W-1:0] c_we,
  input  logic [SHORT_W-1:0] c_hold,
  input  logic [LONG_W-1:0]  c_oe,
  input  logic [LONG_W-1:0]  c_wait,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rdy_act,
  input  logic [DATA_W-1:0] din,
  output logic              req_ready,
  output logic              busy,
  output pmb_phase_e        phase,
  output logic              txn_write,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [DATA_W-1:0] txn_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam logic [LONG_W-1:0] CNT_MAX = '1;

  logic [LONG_W-1:0] cnt;
  logic [LONG_W-1:0] phase_len;
  logic              phase_end;
  logic              wait_ok_q, oe_min_q, got_q, pend_q;
  logic              rd_phase, oe_min_now, capture_now, pend_set, read_done;
  logic [DATA_W-1:0] din_sized;

  assign busy      = (phase != PH_IDLE);
  assign req_ready = !busy;

  always_comb begin
    case (phase)
      PH_SETUP: phase_len = LONG_W'(c_setup);
      PH_ADV:   phase_len = LONG_W'(c_adv);
      PH_MUXA:  phase_len = LONG_W'(c_muxw);
      PH_DATA:  phase_len = LONG_W'(c_we);
      PH_HOLD:  phase_len = LONG_W'(c_hold);
      default:  phase_len = '0;
    endcase
  end
  assign phase_end = (cnt == phase_len);

  assign rd_phase    = (phase == PH_DATA) && !txn_write;
  assign oe_min_now  = oe_min_q || (cnt == c_oe);
  assign capture_now = rd_phase && !got_q && (c_early ? pend_q : (wait_ok_q && rdy_act));
  assign pend_set    = rd_phase && c_early && wait_ok_q && rdy_act && !pend_q && !got_q;
  assign read_done   = (got_q || capture_now) && oe_min_now;
  assign din_sized   = c_wide ? din : {{(DATA_W-NARROW_W){1'b0}}, din[NARROW_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      wait_ok_q <= 1'b0;
      oe_min_q  <= 1'b0;
      got_q     <= 1'b0;
      pend_q    <= 1'b0;
      txn_write <= 1'b0;
      txn_addr  <= '0;
      txn_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture_now;
      if (capture_now) rsp_rdata <= din_sized;
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase     <= PH_SETUP;
            cnt       <= '0;
            txn_write <= req_write;
            txn_addr  <= req_addr;
            txn_wdata <= req_wdata;
            wait_ok_q <= 1'b0;
            oe_min_q  <= 1'b0;
            got_q     <= 1'b0;
            pend_q    <= 1'b0;
          end
        end
        PH_SETUP, PH_ADV, PH_MUXA: begin
          if (phase_end) begin
            cnt <= '0;
            if (phase == PH_SETUP)               phase <= PH_ADV;
            else if (phase == PH_ADV && c_mux)   phase <= PH_MUXA;
            else                                 phase <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DATA: begin
          if (txn_write) begin
            if (phase_end) begin
              phase <= PH_HOLD;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            if (cnt == c_wait) wait_ok_q <= 1'b1;
            if (cnt == c_oe)   oe_min_q  <= 1'b1;
            if (pend_set)      pend_q    <= 1'b1;
            if (capture_now)   got_q     <= 1'b1;
            if (read_done) begin
              phase <= PH_HOLD;
              cnt   <= '0;
            end else if (cnt != CNT_MAX) begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_HOLD: begin
          if (phase_end) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_ACCEPT_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy) else $error("accepted request did not start"); // R1
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid) else $error("response longer than one cycle"); // R9
  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(phase) == PH_DATA && !$past(txn_write))) else $error("response outside read"); // R9
  AST_HOLD_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && $past(phase) != PH_HOLD) |-> $past(phase) == PH_DATA) else $error("hold without data phase"); // R4
  AST_OE_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && $past(phase) == PH_DATA && !txn_write) |-> ($past(cnt) >= $past(c_oe))) else $error("output enable too short"); // R8
endmodule

// File: rtl/pmb_pins.sv
module pmb_pins
  import pmb_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_wide,
  input  logic              c_mux,
  input  logic              c_adv_high,
  input  logic              c_strobe_high,
  input  logic              c_ce_high,
  input  pmb_phase_e        phase,
  input  logic              txn_write,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [DATA_W-1:0] txn_wdata,
  output logic              bus_ce,
  output logic              bus_adv,
  output logic              bus_we,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe
);
  localparam int NSTROBE = 4;

  logic [NSTROBE-1:0] act, high, phys;
  logic               addr_win, data_win;
  logic [DATA_W-1:0]  raw, width_mask;

  assign act[0] = (phase == PH_ADV) || (phase == PH_MUXA) || (phase == PH_DATA) || (phase == PH_HOLD);
  assign act[1] = (phase == PH_ADV);
  assign act[2] = (phase == PH_DATA) && txn_write;
  assign act[3] = (phase == PH_DATA) && !txn_write;
  assign high   = {c_strobe_high, c_strobe_high, c_adv_high, c_ce_high};

  for (genvar i = 0; i < NSTROBE; i++) begin : g_pol
    assign phys[i] = high[i] ? act[i] : ~act[i];
  end

  assign bus_ce  = phys[0];
  assign bus_adv = phys[1];
  assign bus_we  = phys[2];
  assign bus_oe  = phys[3];

  assign addr_win   = c_mux && ((phase == PH_ADV) || (phase == PH_MUXA));
  assign data_win   = txn_write && ((phase == PH_DATA) || (phase == PH_HOLD));
  assign width_mask = c_wide ? '1 : DATA_W'({NARROW_W{1'b1}});

  always_comb begin
    if (addr_win)      raw = DATA_W'(txn_addr);
    else if (data_win) raw = txn_wdata;
    else               raw = '0;
  end

  assign bus_dout = raw & width_mask;
  assign bus_doe  = addr_win || data_win;
  assign bus_addr = (phase != PH_IDLE) ? txn_addr : '0;

  AST_CE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (act[1] || act[2] || act[3]) |-> act[0]) else $error("strobe without chip enable"); // R2
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(act[2] && act[3])) else $error("write and output enable overlap"); // R3
endmodule

// File: rtl/pmb_ctrl.sv
module pmb_ctrl
  import pmb_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_wide,
  input  logic              cfg_mux,
  input  logic              cfg_rdy_early,
  input  logic              cfg_rdy_high,
  input  logic              cfg_adv_high,
  input  logic              cfg_strobe_high,
  input  logic              cfg_ce_high,
  input  logic [3:0]        cfg_t_setup,
  input  logic [3:0]        cfg_t_adv,
  input  logic [3:0]        cfg_t_mux,
  input  logic [3:0]        cfg_t_we,
  input  logic [3:0]        cfg_t_hold,
  input  logic [7:0]        cfg_t_oe,
  input  logic [7:0]        cfg_t_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              bus_ce,
  output logic              bus_adv,
  output logic              bus_we,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_rdy
);
  pmb_cfg_t   cfg_in, cfg;
  pmb_phase_e phase;
  logic              txn_write;
  logic [ADDR_W-1:0] txn_addr;
  logic [DATA_W-1:0] txn_wdata;
  logic              rdy_act;

  always_comb begin
    cfg_in             = '0;
    cfg_in.wide        = cfg_wide;
    cfg_in.mux         = cfg_mux;
    cfg_in.rdy_early   = cfg_rdy_early;
    cfg_in.rdy_high    = cfg_rdy_high;
    cfg_in.adv_high    = cfg_adv_high;
    cfg_in.strobe_high = cfg_strobe_high;
    cfg_in.ce_high     = cfg_ce_high;
    cfg_in.t_setup     = cfg_t_setup;
    cfg_in.t_adv       = cfg_t_adv;
    cfg_in.t_mux       = cfg_t_mux;
    cfg_in.t_we        = cfg_t_we;
    cfg_in.t_hold      = cfg_t_hold;
    cfg_in.t_oe        = cfg_t_oe;
    cfg_in.t_wait      = cfg_t_wait;
  end

  pmb_cfg_regs u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .wr     (cfg_wr),
    .wr_val (cfg_in),
    .cfg    (cfg)
  );

  assign rdy_act = cfg.rdy_high ? bus_rdy : ~bus_rdy;

  pmb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .c_wide    (cfg.wide),
    .c_mux     (cfg.mux),
    .c_early   (cfg.rdy_early),
    .c_setup   (cfg.t_setup),
    .c_adv     (cfg.t_adv),
    .c_muxw    (cfg.t_mux),
    .c_we      (cfg.t_we),
    .c_hold    (cfg.t_hold),
    .c_oe      (cfg.t_oe),
    .c_wait    (cfg.t_wait),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rdy_act   (rdy_act),
    .din       (bus_din),
    .req_ready (req_ready),
    .busy      (busy),
    .phase     (phase),
    .txn_write (txn_write),
    .txn_addr  (txn_addr),
    .txn_wdata (txn_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  pmb_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_pins (
    .clk           (clk),
    .rst_n         (rst_n),
    .c_wide        (cfg.wide),
    .c_mux         (cfg.mux),
    .c_adv_high    (cfg.adv_high),
    .c_strobe_high (cfg.strobe_high),
    .c_ce_high     (cfg.ce_high),
    .phase         (phase),
    .txn_write     (txn_write),
    .txn_addr      (txn_addr),
    .txn_wdata     (txn_wdata),
    .bus_ce        (bus_ce),
    .bus_adv       (bus_adv),
    .bus_we        (bus_we),
    .bus_oe        (bus_oe),
    .bus_addr      (bus_addr),
    .bus_dout      (bus_dout),
    .bus_doe       (bus_doe)
  );
endmodule

// File: tb/pmb_ctrl_test.sv
`timescale 1ns/1ps
module pmb_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_wr = 0, cfg_wide = 0, cfg_mux = 0, cfg_rdy_early = 0, cfg_rdy_high = 0;
  logic cfg_adv_high = 0, cfg_strobe_high = 0, cfg_ce_high = 0;
  logic [3:0] cfg_t_setup = 0, cfg_t_adv = 0, cfg_t_mux = 0, cfg_t_we = 0, cfg_t_hold = 0;
  logic [7:0] cfg_t_oe = 0, cfg_t_wait = 0;
  logic req_valid = 0, req_write = 0;
  logic [27:0] req_addr = 0;
  logic [31:0] req_wdata = 0, bus_din = 0;
  logic bus_rdy = 1;
  logic req_ready, rsp_valid, busy, bus_ce, bus_adv, bus_we, bus_oe, bus_doe;
  logic [31:0] rsp_rdata, bus_dout;
  logic [27:0] bus_addr;

  pmb_ctrl uut (.*);

  int n_total = 0, n_fail = 0;
  // model configuration
  int m_setup = 4, m_adv = 1, m_muxw = 1, m_we = 1, m_hold = 1, m_oe = 1, m_wait = 3;
  bit m_wide = 0, m_mux = 0, m_early = 0, m_rdyh = 0, m_advh = 0, m_strh = 0, m_ceh = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic lvl(bit hi, bit a);
    return hi ? a : !a;
  endfunction

  function automatic logic [31:0] pat(int i);
    return 32'h5EED0000 + 32'(i) * 32'h00030101;
  endfunction

  function automatic logic [31:0] msk(logic [31:0] v);
    return m_wide ? v : (v & 32'h0000FFFF);
  endfunction

  task automatic set_cfg(bit wide, bit mux, bit early, bit rh, bit ah, bit sh, bit ch,
                         int s, int a, int mx, int w, int h, int oe, int wt);
    @(negedge clk);
    cfg_wr = 1; cfg_wide = wide; cfg_mux = mux; cfg_rdy_early = early; cfg_rdy_high = rh;
    cfg_adv_high = ah; cfg_strobe_high = sh; cfg_ce_high = ch;
    cfg_t_setup = 4'(s); cfg_t_adv = 4'(a); cfg_t_mux = 4'(mx); cfg_t_we = 4'(w);
    cfg_t_hold = 4'(h); cfg_t_oe = 8'(oe); cfg_t_wait = 8'(wt);
    m_wide = wide; m_mux = mux; m_early = early; m_rdyh = rh; m_advh = ah; m_strh = sh; m_ceh = ch;
    m_setup = s; m_adv = a; m_muxw = mx; m_we = w; m_hold = h; m_oe = oe; m_wait = wt;
    @(negedge clk);
    cfg_wr = 0;
    bus_rdy = lvl(m_rdyh, 0);
  endtask

  // One transaction, compared against the behavioural timeline on every cycle.
  task automatic run_txn(string ctx, bit wr, logic [27:0] a, logic [31:0] wd, int r, bit poke);
    int S, A, M, D, H, c, k, p1, p2, p3, p4, p5;
    S = m_setup + 1; A = m_adv + 1; M = m_mux ? m_muxw + 1 : 0; H = m_hold + 1; c = -10;
    if (wr) D = m_we + 1;
    else begin
      k = (r > m_wait) ? r : m_wait + 1;
      c = m_early ? k + 1 : k;
      D = ((c > m_oe) ? c : m_oe) + 1;
    end
    p1 = 1 + S; p2 = p1 + A; p3 = p2 + M; p4 = p3 + D; p5 = p4 + H;
    for (int g = 0; g <= p5; g++) begin
      bit e_busy, e_ce, e_adv, e_we, e_oe, e_doe, e_rsp, inmux, indata;
      logic [31:0] e_dout;
      string st;
      @(negedge clk);
      e_busy = (g >= 1) && (g < p5);
      e_ce   = (g >= p1) && (g < p5);
      e_adv  = (g >= p1) && (g < p2);
      e_we   = wr && (g >= p3) && (g < p4);
      e_oe   = !wr && (g >= p3) && (g < p4);
      inmux  = m_mux && (g >= p1) && (g < p3);
      indata = wr && (g >= p3) && (g < p5);
      e_doe  = inmux || indata;
      e_dout = inmux ? msk({4'h0, a}) : (indata ? msk(wd) : 32'h0);
      e_rsp  = !wr && (g == p3 + c + 1);
      st = (g >= p4) ? "R4" : (g >= p3) ? (wr ? "R3" : "R6/R8") : "R2";
      chk({ctx, " R1 busy/ready"}, {busy, req_ready}, {e_busy, !e_busy});
      chk({ctx, " ", st, " R11 strobes"}, {bus_ce, bus_adv, bus_we, bus_oe},
          {lvl(m_ceh, e_ce), lvl(m_advh, e_adv), lvl(m_strh, e_we), lvl(m_strh, e_oe)});
      chk({ctx, " R2 addr bus"}, 64'(bus_addr), e_busy ? 64'(a) : 64'h0);
      chk({ctx, inmux ? " R5 mux data" : " R3/R10 data bus"}, {bus_doe, bus_dout}, {e_doe, e_dout});
      chk({ctx, " R9 rsp_valid"}, 64'(rsp_valid), 64'(e_rsp));
      if (e_rsp)
        chk({ctx, m_early ? " R7 early capture" : " R6 capture", " R10"}, 64'(rsp_rdata), 64'(msk(pat(c))));
      // drive inputs for this cycle
      req_valid = (g == 0); req_write = wr; req_addr = a; req_wdata = wd;
      if (poke && g == 2) begin
        cfg_wr = 1; cfg_wide = !m_wide; cfg_mux = !m_mux; cfg_t_setup = 4'd9;
        cfg_t_we = 4'd13; cfg_t_hold = 4'd7; cfg_ce_high = !m_ceh; cfg_t_oe = 8'd40;
      end else cfg_wr = 0;
      bus_din = (g >= p3) ? pat(g - p3) : 32'hBAD0BAD0;
      bus_rdy = lvl(m_rdyh, !wr && (g >= p3) && (g < p4) && (g - p3 >= r));
    end
    req_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state: idle, every strobe at its inactive (low-active default) level
    chk("R1 reset ready", {busy, req_ready, rsp_valid}, {1'b0, 1'b1, 1'b0});
    chk("R11 R12 reset strobes", {bus_ce, bus_adv, bus_we, bus_oe, bus_doe}, 5'b11110);
    // R12 defaults; R6 ready active during wait window is ignored
    run_txn("R12 default read", 0, 28'h0123456, 32'h0, 0, 0);
    run_txn("R12 default write", 1, 28'h0FEDCBA, 32'hCAFEF00D, 0, 0);
    // wide + mux, late ready stretches output enable
    set_cfg(1, 1, 0, 0, 0, 0, 0, 0, 2, 3, 0, 0, 2, 1);
    run_txn("R8 stretch read", 0, 28'hA5A5A5A, 32'h0, 7, 0);
    run_txn("R5 mux write", 1, 28'h1234567, 32'h89ABCDEF, 0, 0);
    // early ready, all polarities active-high
    set_cfg(1, 0, 1, 1, 1, 1, 1, 2, 0, 5, 6, 3, 9, 2);
    run_txn("R7 early in window", 0, 28'h0000040, 32'h0, 0, 0);
    run_txn("R7 early late", 0, 28'h0000080, 32'h0, 12, 0);
    run_txn("R11 high write", 1, 28'h7777777, 32'h13579BDF, 0, 0);
    // configuration writes while busy are ignored
    run_txn("R12 poke read", 0, 28'h3141592, 32'h0, 4, 1);
    run_txn("R12 poke write", 1, 28'h2718281, 32'h0BADBEEF, 0, 1);
    // narrow mux with mixed polarity
    set_cfg(0, 1, 0, 0, 1, 0, 1, 1, 1, 0, 2, 1, 3, 0);
    run_txn("R10 narrow mux write", 1, 28'hABCDEF1, 32'h12345678, 0, 0);
    run_txn("R10 narrow read", 0, 28'h0FACE00, 32'h0, 2, 0);
    // long counts
    set_cfg(1, 0, 0, 1, 0, 0, 0, 15, 15, 15, 15, 15, 255, 200);
    run_txn("R6 long read", 0, 28'h5555555, 32'h0, 0, 0);
    run_txn("R8 long oe", 0, 28'h6666666, 32'h0, 230, 0);
    run_txn("R4 long write", 1, 28'h4444444, 32'hFFFF0000, 0, 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule